// File: doc/BRIEF.md
# Event Counter Bank Overflow Controller

This block holds a small bank of event counters and the global registers that govern them: eight general counters and one fixed counter. A 64-bit control word switches each counter on or off, steers the overflow interrupt to any of four cores, and can arm a freeze policy. Under that policy, the first overflow that raises an interrupt request switches every counter off at once, so the counts are captured at the moment of the event. A read-only status word keeps sticky overflow flags, an interrupt-pending flag and a change-summary flag. Software can poll the change-summary flag cheaply to learn whether anything new has happened since it last cleared that flag. A separate write-only word clears status bits one at a time.

Software reaches every register through a single-cycle write port and a combinational read port. The register words are: control at address 0, status at 1, clear at 2, general counter i at 3+i, and the fixed counter at 11. Event inputs step the counters. Each core gets a level-sensitive interrupt output.

A small state machine follows the counting phase. It has three states. ST_IDLE means no counter is enabled. ST_COUNT means at least one counter is enabled. ST_FROZEN means the freeze policy has switched the counters off. The transitions are:
- ST_IDLE to ST_COUNT on a control write with a non-zero enable field.
- ST_COUNT to ST_IDLE on a control write with a zero enable field.
- ST_COUNT to ST_FROZEN on a freeze hit.
- ST_FROZEN to ST_COUNT or to ST_IDLE on the next control write, depending on whether that write carries any enable bit.

Top module: `pmu_ovf_ctrl`

## Requirements
- R1: After reset, the control word, the status word, every counter and every core interrupt output are zero.
- R2: Control bits 7..0 enable general counters 7..0. Bit 32 enables the fixed counter. Bits 51..48 route the interrupt to cores 3..0. Bit 63 arms the freeze policy. All other control bits read as zero whatever was written.
- R3: A counter increments by exactly one on each cycle in which both its event input and its enable are high, and holds otherwise. Writing a counter's address loads the written value.
- R4: A counter at all ones that increments wraps to zero. On that same edge, its status flag is set: status bit i for general counter i, status bit 32 for the fixed counter.
- R5: Status flags are sticky. Writing a 1 to bit b of the clear word clears status bit b, and writing a 0 has no effect. The clear word reads as zero. Writes to the status address are ignored.
- R6: If a clear and a new overflow hit the same status bit in the same cycle, the bit stays set.
- R7: Status bit 61 is set when a counter overflows while at least one interrupt routing bit is set. It is not set when no routing bit is set.
- R8: Status bit 63 is set whenever any other status bit goes from 0 to 1. Writing a 1 to clear-word bit 63 clears it, unless another status bit rises in that same cycle.
- R9: Core n's interrupt output is high exactly while status bit 61, routing bit 48+n and the global interrupt enable input are all high.
- R10: When freeze (control bit 63) is set and an interrupt request occurs, all enable bits (7..0 and 32) clear on that edge, while the routing and freeze bits keep their values. Enable bits written in that same cycle are discarded.
- R11: While frozen, or while no enable is set, no counter changes on events. Counting resumes only after software writes enable bits again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register word address for reads and writes |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for reg_addr, combinational |
| evt_gp | input | NUM_GP | Event inputs for the general counters |
| evt_fix | input | 1 | Event input for the fixed counter |
| offcore_irq_en | input | 1 | Global enable for the core interrupt outputs |
| core_irq | output | NUM_CORES | Level interrupt, one per core |

## Verification
A table of control words paired with one-cycle event patterns separates the enable decoding from the event decoding. It includes all-ones, alternating and sparse patterns, as well as words made only of reserved or routing bits. A counter moves only when its own enable and its own event coincide.

Directed wrap scenarios run with narrow counters. They tell apart four cases: an overflow with routing and one without, an overflow with freeze armed and one without, a clear that lands together with an overflow, and a change-summary clear that lands together with a rise. Other checks cover the interrupt outputs with the global enable off and on, the freeze hit that arrives together with a software enable write, and the resumption of counting after a freeze.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
    localparam int REG_W      = 64;
    localparam int FIX_EN_BIT = 32;
    localparam int ROUTE_LO   = 48;
    localparam int FRZ_BIT    = 63;
    localparam int FIX_OVF    = 32;
    localparam int PMI_BIT    = 61;
    localparam int CHG_BIT    = 63;
    localparam int ADDR_CTRL  = 0;
    localparam int ADDR_STAT  = 1;
    localparam int ADDR_CLR   = 2;
    localparam int ADDR_CNT0  = 3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COUNT,
        ST_FROZEN
    } pmu_state_e;
endpackage

// File: rtl/pmu_counter.sv
module pmu_counter #(
    parameter int CNT_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             evt,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    output logic [CNT_W-1:0] value,
    output logic             ovf
);
    logic step;

    always_comb begin
        step = en & evt & ~ld;
        ovf  = step & (value == {CNT_W{1'b1}});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value <= '0;
        end else if (ld) begin
            value <= ld_val;
        end else if (step) begin
            value <= value + 1'b1;
        end
    end

    AST_CNT_WRAP: // R4
        assert property (@(posedge clk) disable iff (!rst_n) ovf |=> (value == '0));
    AST_CNT_HOLD: // R3
        assert property (@(posedge clk) disable iff (!rst_n) (!ld && !(en && evt)) |=> $stable(value));
endmodule

// File: rtl/pmu_ctrl.sv
module pmu_ctrl
    import pmu_pkg::*;
#(
    parameter int NUM_GP    = 8,
    parameter int NUM_CORES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_ctrl,
    input  logic [REG_W-1:0]     wdata,
    input  logic                 irq_req,
    output logic [REG_W-1:0]     ctrl_q,
    output logic [NUM_GP-1:0]    gp_en,
    output logic                 fix_en,
    output logic [NUM_CORES-1:0] route
);
    localparam logic [REG_W-1:0] GP_MASK    = (REG_W'(1) << NUM_GP) - 1;
    localparam logic [REG_W-1:0] EN_MASK    = GP_MASK | (REG_W'(1) << FIX_EN_BIT);
    localparam logic [REG_W-1:0] ROUTE_MASK = ((REG_W'(1) << NUM_CORES) - 1) << ROUTE_LO;
    localparam logic [REG_W-1:0] WR_MASK    = EN_MASK | ROUTE_MASK | (REG_W'(1) << FRZ_BIT);

    pmu_state_e       state_q, state_d;
    logic [REG_W-1:0] ctrl_d;
    logic             freeze_hit;
    logic             wr_any_en;

    always_comb begin
        freeze_hit = irq_req & ctrl_q[FRZ_BIT];
        wr_any_en  = |(wdata & EN_MASK);
        ctrl_d     = ctrl_q;
        if (wr_ctrl) begin
            ctrl_d = wdata & WR_MASK;
        end
        if (freeze_hit) begin
            ctrl_d = ctrl_d & ~EN_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_ctrl && wr_any_en) state_d = ST_COUNT;
            end
            ST_COUNT: begin
                if (freeze_hit)                   state_d = ST_FROZEN;
                else if (wr_ctrl && !wr_any_en)   state_d = ST_IDLE;
            end
            ST_FROZEN: begin
                if (wr_ctrl) state_d = wr_any_en ? ST_COUNT : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        route  = ctrl_q[ROUTE_LO +: NUM_CORES];
        gp_en  = '0;
        fix_en = 1'b0;
        if (state_q == ST_COUNT) begin
            gp_en  = ctrl_q[NUM_GP-1:0];
            fix_en = ctrl_q[FIX_EN_BIT];
        end
    end

    AST_FREEZE_STOP: // R10
        assert property (@(posedge clk) disable iff (!rst_n) freeze_hit |=> ((ctrl_q & EN_MASK) == '0));
    AST_STATE_MATCH: // R11
        assert property (@(posedge clk) disable iff (!rst_n) (state_q != ST_COUNT) |-> ((ctrl_q & EN_MASK) == '0));
    AST_FREEZE_KEEPS_ROUTE: // R10
        assert property (@(posedge clk) disable iff (!rst_n) (freeze_hit && !wr_ctrl) |=> ((ctrl_q & ROUTE_MASK) == ($past(ctrl_q) & ROUTE_MASK)));
endmodule

// File: rtl/pmu_status.sv
module pmu_status
    import pmu_pkg::*;
#(
    parameter int NUM_GP = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_GP-1:0] ovf_gp,
    input  logic              ovf_fix,
    input  logic              route_any,
    input  logic              clr_wr,
    input  logic [REG_W-1:0]  clr_data,
    output logic [REG_W-1:0]  status_q,
    output logic              irq_req
);
    localparam logic [REG_W-1:0] KEEP_MASK = ((REG_W'(1) << NUM_GP) - 1)
                                           | (REG_W'(1) << FIX_OVF)
                                           | (REG_W'(1) << PMI_BIT)
                                           | (REG_W'(1) << CHG_BIT);

    logic [REG_W-1:0] set_vec, clr_vec, status_d;
    logic             any_rise;

    always_comb begin
        irq_req = ((|ovf_gp) | ovf_fix) & route_any;
        set_vec = '0;
        set_vec[NUM_GP-1:0] = ovf_gp;
        set_vec[FIX_OVF]    = ovf_fix;
        set_vec[PMI_BIT]    = irq_req;
        any_rise            = |(set_vec & ~status_q);
        set_vec[CHG_BIT]    = any_rise;
        clr_vec  = clr_wr ? clr_data : '0;
        status_d = ((status_q & ~clr_vec) | set_vec) & KEEP_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= status_d;
        end
    end

    AST_FLAG_STICKY: // R5
        assert property (@(posedge clk) disable iff (!rst_n) !clr_wr |=> ((~status_q & $past(status_q)) == '0));
    AST_CHG_RISE: // R8
        assert property (@(posedge clk) disable iff (!rst_n) any_rise |=> status_q[CHG_BIT]);
    AST_PMI_SET: // R7
        assert property (@(posedge clk) disable iff (!rst_n) irq_req |=> status_q[PMI_BIT]);

    for (genvar i = 0; i < NUM_GP; i++) begin : g_ovf_chk
        AST_OVF_WINS: // R6
            assert property (@(posedge clk) disable iff (!rst_n) ovf_gp[i] |=> status_q[i]);
    end
endmodule

// File: rtl/pmu_ovf_ctrl.sv
module pmu_ovf_ctrl
    import pmu_pkg::*;
#(
    parameter int NUM_GP    = 8,
    parameter int NUM_CORES = 4,
    parameter int CNT_W     = 48,
    parameter int ADDR_W    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_wr,
    input  logic [63:0]          reg_wdata,
    output logic [63:0]          reg_rdata,
    input  logic [NUM_GP-1:0]    evt_gp,
    input  logic                 evt_fix,
    input  logic                 offcore_irq_en,
    output logic [NUM_CORES-1:0] core_irq
);
    localparam int FIX_ADDR = ADDR_CNT0 + NUM_GP;

    logic [REG_W-1:0]     ctrl_q, status_q;
    logic [NUM_GP-1:0]    gp_en, gp_ovf, gp_ld;
    logic                 fix_en, fix_ovf, fix_ld;
    logic [NUM_CORES-1:0] route;
    logic                 irq_req;
    logic                 wr_ctrl, wr_clr;
    logic [CNT_W-1:0]     gp_cnt [NUM_GP];
    logic [CNT_W-1:0]     fix_cnt;

    always_comb begin
        wr_ctrl = reg_wr && (reg_addr == ADDR_W'(ADDR_CTRL));
        wr_clr  = reg_wr && (reg_addr == ADDR_W'(ADDR_CLR));
        fix_ld  = reg_wr && (reg_addr == ADDR_W'(FIX_ADDR));
    end

    pmu_ctrl #(.NUM_GP(NUM_GP), .NUM_CORES(NUM_CORES)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ctrl (wr_ctrl),
        .wdata   (reg_wdata),
        .irq_req (irq_req),
        .ctrl_q  (ctrl_q),
        .gp_en   (gp_en),
        .fix_en  (fix_en),
        .route   (route)
    );

    pmu_status #(.NUM_GP(NUM_GP)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .ovf_gp    (gp_ovf),
        .ovf_fix   (fix_ovf),
        .route_any (|route),
        .clr_wr    (wr_clr),
        .clr_data  (reg_wdata),
        .status_q  (status_q),
        .irq_req   (irq_req)
    );

    for (genvar i = 0; i < NUM_GP; i++) begin : g_gp
        assign gp_ld[i] = reg_wr && (reg_addr == ADDR_W'(ADDR_CNT0 + i));
        pmu_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (gp_en[i]),
            .evt    (evt_gp[i]),
            .ld     (gp_ld[i]),
            .ld_val (reg_wdata[CNT_W-1:0]),
            .value  (gp_cnt[i]),
            .ovf    (gp_ovf[i])
        );
    end

    pmu_counter #(.CNT_W(CNT_W)) u_fix (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (fix_en),
        .evt    (evt_fix),
        .ld     (fix_ld),
        .ld_val (reg_wdata[CNT_W-1:0]),
        .value  (fix_cnt),
        .ovf    (fix_ovf)
    );

    for (genvar n = 0; n < NUM_CORES; n++) begin : g_irq
        assign core_irq[n] = status_q[PMI_BIT] & route[n] & offcore_irq_en;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(ADDR_CTRL)) begin
            reg_rdata = ctrl_q;
        end else if (reg_addr == ADDR_W'(ADDR_STAT)) begin
            reg_rdata = status_q;
        end else if (reg_addr == ADDR_W'(FIX_ADDR)) begin
            reg_rdata = REG_W'(fix_cnt);
        end else begin
            for (int i = 0; i < NUM_GP; i++) begin
                if (reg_addr == ADDR_W'(ADDR_CNT0 + i)) reg_rdata = REG_W'(gp_cnt[i]);
            end
        end
    end

    AST_IRQ_NEEDS_PMI: // R9
        assert property (@(posedge clk) disable iff (!rst_n) (|core_irq) |-> (status_q[PMI_BIT] && offcore_irq_en));
endmodule

// File: tb/pmu_ovf_ctrl_test.sv
`timescale 1ns/1ps
module pmu_ovf_ctrl_test;
    localparam logic [63:0] MASK = 64'h800F_0001_0000_00FF;
    localparam int A_CTRL = 0, A_STAT = 1, A_CLR = 2, A_FIX = 11;

    // [72:9] control word, [8] fixed event, [7:0] general events
    localparam logic [72:0] VEC [6] = '{
        {64'hFFFF_FFFF_FFFF_FFFF, 9'h1FF},
        {64'h0000_0000_0000_00A5, 9'h0FF},
        {64'h0000_0001_0000_0000, 9'h100},
        {64'h0000_0000_0000_003C, 9'h155},
        {64'h7FF0_FFFE_FFFF_FF00, 9'h1FF},
        {64'h0000_0001_0000_00FF, 9'h000}
    };

    logic        clk = 0;
    logic        rst_n = 0;
    logic [3:0]  reg_addr = '0;
    logic        reg_wr = 0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic [7:0]  evt_gp = '0;
    logic        evt_fix = 0;
    logic        offcore_irq_en = 0;
    logic [3:0]  core_irq;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done = 0;
    logic [63:0] rv;

    always #4 clk = ~clk;

    pmu_ovf_ctrl #(.CNT_W(4)) uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_gp(evt_gp),
        .evt_fix(evt_fix), .offcore_irq_en(offcore_irq_en), .core_irq(core_irq)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [63:0] d);
        @(negedge clk);
        reg_addr = 4'(a); reg_wdata = d; reg_wr = 1;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input int a, output logic [63:0] d);
        reg_addr = 4'(a);
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse(input logic [7:0] g, input logic f);
        @(negedge clk);
        evt_gp = g; evt_fix = f;
        @(negedge clk);
        evt_gp = '0; evt_fix = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        rd(A_CTRL, rv); chk("R1 ctrl", rv, 0);
        rd(A_STAT, rv); chk("R1 status", rv, 0);
        rd(3, rv);      chk("R1 counter0", rv, 0);
        chk("R1 core_irq", 64'(core_irq), 0);
        rst_n = 1;
        @(negedge clk);

        // table: R2 decoding and R3 single-cycle counting
        foreach (VEC[k]) begin
            logic [63:0] cw, rb;
            logic [8:0]  ev;
            cw = VEC[k][72:9]; ev = VEC[k][8:0];
            wr(A_CTRL, cw);
            rd(A_CTRL, rb); chk("R2 ctrl readback", rb, cw & MASK);
            for (int c = 3; c <= A_FIX; c++) wr(c, 0);
            pulse(ev[7:0], ev[8]);
            for (int i = 0; i < 8; i++) begin
                rd(3 + i, rv); chk("R3 table gp", rv, 64'(rb[i] & ev[i]));
            end
            rd(A_FIX, rv); chk("R3 table fixed", rv, 64'(rb[32] & ev[8]));
        end
        wr(A_CTRL, 0);

        // R3 multi-cycle count, load, hold when disabled
        wr(A_CTRL, 64'h4);
        wr(5, 0);
        @(negedge clk); evt_gp = 8'h04;
        repeat (5) @(negedge clk);
        evt_gp = 0;
        repeat (3) @(negedge clk);
        rd(5, rv); chk("R3 five events", rv, 5);
        wr(6, 9);
        rd(6, rv); chk("R3 load", rv, 9);
        pulse(8'h08, 0);
        rd(6, rv); chk("R3 disabled hold", rv, 9);

        // R4 wrap without routing; R8 change flag; R7 no pmi
        wr(A_CLR, '1);
        wr(A_CTRL, 64'h2);
        wr(4, 15);
        pulse(8'h02, 0);
        rd(4, rv);      chk("R4 wrap to zero", rv, 0);
        rd(A_STAT, rv); chk("R4 R8 R7 status", rv, 64'h8000_0000_0000_0002);

        // R5 clear semantics
        wr(A_CLR, 0);
        rd(A_STAT, rv); chk("R5 zero clear no effect", rv, 64'h8000_0000_0000_0002);
        wr(A_STAT, '1);
        rd(A_STAT, rv); chk("R5 status write ignored", rv, 64'h8000_0000_0000_0002);
        rd(A_CLR, rv);  chk("R5 clear reads zero", rv, 0);
        wr(A_CLR, 64'h2);
        rd(A_STAT, rv); chk("R5 clear one bit", rv, 64'h8000_0000_0000_0000);
        wr(A_CLR, 64'h8000_0000_0000_0000);
        rd(A_STAT, rv); chk("R8 chg cleared", rv, 0);

        // R6 overflow beats clear
        wr(A_CTRL, 64'h1);
        wr(3, 15);
        pulse(8'h01, 0);
        wr(3, 15);
        @(negedge clk);
        evt_gp = 8'h01; reg_addr = 4'(A_CLR); reg_wdata = 64'h1; reg_wr = 1;
        @(negedge clk);
        evt_gp = 0; reg_wr = 0;
        rd(A_STAT, rv); chk("R6 overflow wins", rv, 64'h8000_0000_0000_0001);

        // R8 rise beats change-flag clear
        wr(A_CTRL, 64'h10);
        wr(7, 15);
        @(negedge clk);
        evt_gp = 8'h10; reg_addr = 4'(A_CLR); reg_wdata = 64'h8000_0000_0000_0000; reg_wr = 1;
        @(negedge clk);
        evt_gp = 0; reg_wr = 0;
        rd(A_STAT, rv); chk("R8 rise wins", rv, 64'h8000_0000_0000_0011);
        wr(A_CLR, '1);

        // R7 / R9 routed fixed-counter overflow
        wr(A_CTRL, 64'h000A_0001_0000_0000);
        wr(A_FIX, 15);
        pulse(0, 1);
        rd(A_STAT, rv); chk("R7 pmi set", rv, 64'hA000_0001_0000_0000);
        chk("R9 gated off", 64'(core_irq), 0);
        offcore_irq_en = 1; #1;
        chk("R9 routed cores", 64'(core_irq), 64'hA);
        wr(A_CLR, 64'h2000_0000_0000_0000);
        #1; chk("R9 drops with pmi", 64'(core_irq), 0);
        wr(A_CLR, '1);

        // R10 freeze armed but no routing: no freeze
        wr(A_CTRL, 64'h8000_0000_0000_0001);
        wr(3, 15);
        pulse(8'h01, 0);
        rd(A_CTRL, rv); chk("R10 no route no freeze", rv, 64'h8000_0000_0000_0001);
        wr(A_CLR, '1);

        // R10 freeze hit
        wr(A_CTRL, 64'h8001_0000_0000_0021);
        wr(3, 15);
        wr(8, 0);
        pulse(8'h21, 0);
        rd(A_CTRL, rv); chk("R10 enables cleared", rv, 64'h8001_0000_0000_0000);
        rd(8, rv);      chk("R10 same-edge count", rv, 1);
        rd(A_STAT, rv); chk("R10 status", rv, 64'hA000_0000_0000_0001);
        #1; chk("R9 core0 irq", 64'(core_irq), 1);
        @(negedge clk); evt_gp = 8'h20;
        repeat (3) @(negedge clk);
        evt_gp = 0;
        rd(8, rv); chk("R11 frozen no count", rv, 1);
        wr(A_CTRL, 64'h8001_0000_0000_0020);
        @(negedge clk); evt_gp = 8'h20;
        repeat (2) @(negedge clk);
        evt_gp = 0;
        rd(8, rv); chk("R11 resume", rv, 3);

        // R10 freeze beats simultaneous enable write
        wr(A_CLR, '1);
        wr(A_CTRL, 64'h8001_0000_0000_0001);
        wr(3, 15);
        wr(4, 0);
        @(negedge clk);
        evt_gp = 8'h01; reg_addr = 4'(A_CTRL); reg_wdata = 64'h8001_0000_0000_0003; reg_wr = 1;
        @(negedge clk);
        evt_gp = 0; reg_wr = 0;
        rd(A_CTRL, rv); chk("R10 write loses", rv, 64'h8001_0000_0000_0000);
        pulse(8'h02, 0);
        rd(4, rv); chk("R11 frozen counter1", rv, 0);

        // R11 idle: nothing counts
        wr(A_CTRL, 0);
        pulse(8'hFF, 1);
        rd(8, rv); chk("R11 idle no count", rv, 3);

        // R1 reset mid-run
        @(negedge clk); rst_n = 0;
        repeat (2) @(negedge clk);
        rd(A_CTRL, rv); chk("R1 ctrl after reset", rv, 0);
        rd(A_STAT, rv); chk("R1 status after reset", rv, 0);
        rd(8, rv);      chk("R1 counter after reset", rv, 0);
        chk("R1 irq after reset", 64'(core_irq), 0);
        rst_n = 1;

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule